// File: doc/BRIEF.md
# LED Channel Effect Engine

This block turns nine channel configuration bytes into the 6-bit current codes that feed a bank of LED current DACs. Each byte picks one of four behaviours for its channel: a steady code, an on/off blink, a linear ramp toward the programmed code or toward zero, or use of the pin as an open-drain general purpose output. Blink and ramp timing are shared by all channels and chosen through two 2-bit selectors. Both run from one tick enable, which a prescaler divides by `TICK_DIV` into a base step.

An external enable pin can take over any set of pre-selected channels. A selected steady, blink or output channel is dark while the pin is low. A selected ramp channel takes its ramp direction from the pin and ignores the direction input. The block reports the end of every blink period and every completed ramp to zero with single-cycle pulses, which a supply controller can use to reset its boost mode.

Top module: `led_effect_engine`

## Requirements
- R1: Channel byte bits [7:6] select the mode: 00 steady (code = bits [5:0]), 01 blink, 10 ramp, 11 open-drain output. In mode 11 the channel's code output is 0, and its `gpo_o` bit is 1 when bits [5:0] are nonzero and the channel is not gated off.
- R2: A code of zero in bits [5:0] gives code output 0 and `gpo_o` low in every mode.
- R3: In blink mode the code is shown for an on-window and zero for the rest of a shared period. `blink_sel_i[1]` picks the period (0: `BLK_PER_SHORT`, 1: `BLK_PER_LONG` base steps). `blink_sel_i[0]` picks the on-window (0: `BLK_ON_LONG`, 1: `BLK_ON_SHORT` base steps).
- R4: `blink_end_o` is a one-cycle pulse at the end of every blink period, so consecutive pulses are one period apart.
- R5: `grad_sel_i` = 00 disables ramping, and ramp channels then show their code steadily. Values 01, 10 and 11 move a ramp channel by one code step every 1, 2 or 4 base steps.
- R6: A ramp going up saturates at the programmed code. If the code is lowered below the current level, the output drops to the new code within two cycles.
- R7: A ramp going down stops at zero. `ramp_done_o` pulses for exactly one cycle when any channel's ramp reaches zero.
- R8: When a channel's `enu_sel_i` bit is set and `enu_pin_i` is low, its steady, blink or output behaviour is off: code 0 and `gpo_o` low. The pin passes through a two-stage synchronizer.
- R9: For a ramp channel whose `enu_sel_i` bit is set, `ramp_up_i` is ignored. The pin high ramps up to the code, and the pin low ramps down to zero, pulsing `ramp_done_o`.
- R10: A base step occurs every `TICK_DIV` cycles in which `tick_i` is high. While `tick_i` stays low, ramps and blink timing do not advance.
- R11: While `rst` is high, all code outputs, `gpo_o`, `ramp_done_o` and `blink_end_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase enable, one pulse per tick |
| chan_cfg_i | input | NCH*8 | Channel bytes, channel k at bits [8k+7:8k] |
| ramp_up_i | input | 1 | Ramp direction for channels not under pin control: 1 up, 0 down |
| blink_sel_i | input | 2 | Blink period and on-window select |
| grad_sel_i | input | 2 | Ramp step rate select, 00 disables ramping |
| enu_sel_i | input | NCH | Channels placed under control of the enable pin |
| enu_pin_i | input | 1 | Asynchronous external enable pin |
| code_o | output | NCH*6 | Effective current codes, channel k at bits [6k+5:6k] |
| gpo_o | output | NCH | Open-drain pull-down enables |
| ramp_done_o | output | 1 | Pulse when a downward ramp reaches zero |
| blink_end_o | output | 1 | Pulse at the end of each blink period |

## Verification
A wrong prescaler or step counter shows up as a changed spacing between successive code steps of a ramping channel, which is visible within one step interval. A broken blink counter shows up as a wrong on-count across one period, or a wrong gap between `blink_end_o` pulses, within one period. A wrong level register shows up as a ramp that overshoots, skips the clamp or never reaches zero. Those faults appear within two cycles of a code change, or as a missing or doubled `ramp_done_o` pulse by the end of the ramp. A broken enable path shows up at a selected channel's outputs three cycles after the pin moves.

// File: rtl/led_fx_pkg.sv
package led_fx_pkg;
  localparam int CFG_W  = 8;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    MODE_STEADY = 2'b00,
    MODE_BLINK  = 2'b01,
    MODE_RAMP   = 2'b10,
    MODE_GPO    = 2'b11
  } chan_mode_e;
endpackage

// File: rtl/led_fx_timebase.sv
module led_fx_timebase #(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [1:0] grad_sel_i,
  output logic       base_stb_o,
  output logic       grad_stb_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [1:0]    gcnt_q;
  logic [1:0]    glim;

  // prescaler: one base step every TICK_DIV ticks
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q      <= '0;
      base_stb_o <= 1'b0;
    end else begin
      base_stb_o <= 1'b0;
      if (tick_i) begin
        if (pre_q == PLAST) begin
          pre_q      <= '0;
          base_stb_o <= 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  // ramp step interval in base steps: 1, 2 or 4
  always_comb begin
    case (grad_sel_i)
      2'b10:   glim = 2'd1;
      2'b11:   glim = 2'd3;
      default: glim = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt_q     <= '0;
      grad_stb_o <= 1'b0;
    end else begin
      grad_stb_o <= 1'b0;
      if (grad_sel_i == 2'b00) begin
        gcnt_q <= '0;
      end else if (base_stb_o) begin
        if (gcnt_q >= glim) begin
          gcnt_q     <= '0;
          grad_stb_o <= 1'b1;
        end else begin
          gcnt_q <= gcnt_q + 1'b1;
        end
      end
    end
  end

  AST_STEP_AFTER_BASE: assert property (@(posedge clk) disable iff (rst)
    grad_stb_o |-> $past(base_stb_o)); // R5

  generate
    if (TICK_DIV > 1) begin : g_gap
      AST_BASE_GAP: assert property (@(posedge clk) disable iff (rst)
        base_stb_o |=> !base_stb_o); // R10
    end
  endgenerate
endmodule

// File: rtl/led_fx_blink.sv
module led_fx_blink #(
  parameter int ON_LONG   = 167,
  parameter int ON_SHORT  = 42,
  parameter int PER_SHORT = 333,
  parameter int PER_LONG  = 667
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       base_stb_i,
  input  logic [1:0] blink_sel_i,
  output logic       on_o,
  output logic       end_o
);
  localparam int CW = $clog2(PER_LONG + 1);
  localparam logic [CW-1:0] PS_M1 = CW'(PER_SHORT - 1);
  localparam logic [CW-1:0] PL_M1 = CW'(PER_LONG - 1);
  localparam logic [CW-1:0] ONL   = CW'(ON_LONG);
  localparam logic [CW-1:0] ONS   = CW'(ON_SHORT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic [CW-1:0] onlen;

  assign last  = blink_sel_i[1] ? PL_M1 : PS_M1;
  assign onlen = blink_sel_i[0] ? ONS : ONL;
  assign on_o  = (cnt_q < onlen);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      end_o <= 1'b0;
    end else begin
      end_o <= 1'b0;
      if (base_stb_i) begin
        if (cnt_q >= last) begin
          cnt_q <= '0;
          end_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
    end_o |=> !end_o); // R4
  AST_END_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    end_o |-> $past(base_stb_i)); // R4
endmodule

// File: rtl/led_fx_channel.sv
module led_fx_channel
  import led_fx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              ramp_up_i,
  input  logic              enu_sel_i,
  input  logic              enu_i,
  input  logic              blink_on_i,
  input  logic              grad_en_i,
  input  logic              grad_stb_i,
  output logic [CODE_W-1:0] code_o,
  output logic              gpo_o,
  output logic              done_o
);
  chan_mode_e        mode;
  logic [CODE_W-1:0] code;
  logic              gate;
  logic              go_up;
  logic [CODE_W-1:0] lvl_d;
  logic              gpo_d;

  assign mode  = chan_mode_e'(cfg_i[7:6]);
  assign code  = cfg_i[CODE_W-1:0];
  assign gate  = !enu_sel_i || enu_i;
  assign go_up = enu_sel_i ? enu_i : ramp_up_i;

  always_comb begin
    lvl_d  = code_o;
    gpo_d  = 1'b0;
    done_o = 1'b0;
    case (mode)
      MODE_STEADY: lvl_d = gate ? code : '0;
      MODE_BLINK:  lvl_d = (gate && blink_on_i) ? code : '0;
      MODE_RAMP: begin
        if (!grad_en_i) begin
          lvl_d = gate ? code : '0;
        end else if (code_o > code) begin
          lvl_d = code;
        end else if (grad_stb_i) begin
          if (go_up) begin
            if (code_o < code) lvl_d = code_o + 1'b1;
          end else if (code_o != '0) begin
            lvl_d  = code_o - 1'b1;
            done_o = (code_o == CODE_W'(1));
          end
        end
      end
      default: begin
        lvl_d = '0;
        gpo_d = gate && (code != '0);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o <= '0;
      gpo_o  <= 1'b0;
    end else begin
      code_o <= lvl_d;
      gpo_o  <= gpo_d;
    end
  end

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (code_o == '0)); // R7
  AST_ENU_DARK: assert property (@(posedge clk) disable iff (rst)
    (enu_sel_i && !enu_i && cfg_i[7:6] != 2'b10) |=> (code_o == '0 && !gpo_o)); // R8
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cfg_i == $past(cfg_i)) |-> (code_o <= cfg_i[CODE_W-1:0])); // R6
  AST_GPO_MODE: assert property (@(posedge clk) disable iff (rst)
    gpo_o |-> ($past(cfg_i[7:6]) == 2'b11)); // R1
endmodule

// File: rtl/led_effect_engine.sv
module led_effect_engine
  import led_fx_pkg::*;
#(
  parameter int NCH           = 9,
  parameter int TICK_DIV      = 4,
  parameter int BLK_ON_LONG   = 167,
  parameter int BLK_ON_SHORT  = 42,
  parameter int BLK_PER_SHORT = 333,
  parameter int BLK_PER_LONG  = 667,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_i,
  input  logic [NCH*CFG_W-1:0]  chan_cfg_i,
  input  logic                  ramp_up_i,
  input  logic [1:0]            blink_sel_i,
  input  logic [1:0]            grad_sel_i,
  input  logic [NCH-1:0]        enu_sel_i,
  input  logic                  enu_pin_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH-1:0]        gpo_o,
  output logic                  ramp_done_o,
  output logic                  blink_end_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   enu_s;
  logic                   base_stb;
  logic                   grad_stb;
  logic                   blink_on;
  logic [NCH-1:0]         done_v;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], enu_pin_i};
  end
  assign enu_s = sync_q[SYNC_STAGES-1];

  led_fx_timebase #(.TICK_DIV(TICK_DIV)) tb_i (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .grad_sel_i (grad_sel_i),
    .base_stb_o (base_stb),
    .grad_stb_o (grad_stb)
  );

  led_fx_blink #(
    .ON_LONG   (BLK_ON_LONG),
    .ON_SHORT  (BLK_ON_SHORT),
    .PER_SHORT (BLK_PER_SHORT),
    .PER_LONG  (BLK_PER_LONG)
  ) blk_i (
    .clk         (clk),
    .rst         (rst),
    .base_stb_i  (base_stb),
    .blink_sel_i (blink_sel_i),
    .on_o        (blink_on),
    .end_o       (blink_end_o)
  );

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      led_fx_channel ch_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_i      (chan_cfg_i[k*CFG_W +: CFG_W]),
        .ramp_up_i  (ramp_up_i),
        .enu_sel_i  (enu_sel_i[k]),
        .enu_i      (enu_s),
        .blink_on_i (blink_on),
        .grad_en_i  (grad_sel_i != 2'b00),
        .grad_stb_i (grad_stb),
        .code_o     (code_o[k*CODE_W +: CODE_W]),
        .gpo_o      (gpo_o[k]),
        .done_o     (done_v[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ramp_done_o <= 1'b0;
    else     ramp_done_o <= |done_v;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ramp_done_o |=> !ramp_done_o); // R7
endmodule

// File: tb/led_effect_engine_tb.sv
module led_effect_engine_tb_top;
  localparam int NCH = 9;
  localparam int TDIV = 2;
  localparam int ONL = 8;
  localparam int ONS = 2;
  localparam int PS = 16;
  localparam int PL = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [7:0] cfg [NCH];
  logic [NCH*8-1:0] chan_cfg;
  logic ramp_up = 1'b0;
  logic [1:0] bsel = 2'b00;
  logic [1:0] gsel = 2'b00;
  logic [NCH-1:0] esel = '0;
  logic epin = 1'b0;
  logic [NCH*6-1:0] code;
  logic [NCH-1:0] gpo;
  logic rdone;
  logic bend;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NCH; k++) chan_cfg[k*8 +: 8] = cfg[k];
  end

  led_effect_engine #(
    .NCH(NCH), .TICK_DIV(TDIV), .BLK_ON_LONG(ONL), .BLK_ON_SHORT(ONS),
    .BLK_PER_SHORT(PS), .BLK_PER_LONG(PL), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .chan_cfg_i(chan_cfg),
    .ramp_up_i(ramp_up), .blink_sel_i(bsel), .grad_sel_i(gsel),
    .enu_sel_i(esel), .enu_pin_i(epin), .code_o(code), .gpo_o(gpo),
    .ramp_done_o(rdone), .blink_end_o(bend)
  );

  // {ch[4], cfg[8], sel, pin, exp_code[6], exp_gpo}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {4'd0, 8'h2A, 1'b0, 1'b0, 6'd42, 1'b0},  // R1 steady
    {4'd3, 8'h00, 1'b0, 1'b0, 6'd0,  1'b0},  // R2 zero
    {4'd4, 8'hC5, 1'b0, 1'b0, 6'd0,  1'b1},  // R1 output mode
    {4'd4, 8'hC0, 1'b0, 1'b0, 6'd0,  1'b0},  // R2 output zero
    {4'd8, 8'h3F, 1'b1, 1'b0, 6'd0,  1'b0},  // R8 gated
    {4'd8, 8'h3F, 1'b1, 1'b1, 6'd63, 1'b0},  // R8 enabled
    {4'd7, 8'hC1, 1'b1, 1'b0, 6'd0,  1'b0},  // R8 output gated
    {4'd7, 8'hC1, 1'b1, 1'b1, 6'd0,  1'b1},  // R8 output enabled
    {4'd5, 8'h91, 1'b0, 1'b0, 6'd17, 1'b0},  // R5 ramp disabled
    {4'd6, 8'h01, 1'b0, 1'b0, 6'd1,  1'b0}   // R1 minimum code
  };

  function automatic int ch_code(int ch);
    return int'(code[ch*6 +: 6]);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < NCH; k++) cfg[k] = 8'h00;
  endtask

  task automatic wait_bend();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (bend) return;
    end
  endtask

  // gap in cycles between two successive code changes of a channel
  task automatic step_gap(int ch, output int gap);
    int old;
    old = ch_code(ch);
    gap = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ch_code(ch) != old) break;
    end
    old = ch_code(ch);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      gap++;
      if (ch_code(ch) != old) break;
    end
  endtask

  initial begin
    clear_cfg();
    cyc(4);
    check(code == '0 && gpo == '0 && !rdone && !bend, "R11 reset", int'(|code), 0);
    rst = 1'b0;
    tick = 1'b1;
    ramp_up = 1'b1;

    // table of static cases
    for (int v = 0; v < NV; v++) begin
      int ch;
      ch = int'(VEC[v][20:17]);
      clear_cfg();
      esel = '0;
      cfg[ch] = VEC[v][16:9];
      esel[ch] = VEC[v][8];
      epin = VEC[v][7];
      cyc(6);
      check(ch_code(ch) == int'(VEC[v][6:1]), $sformatf("R1/R2/R8 vector %0d code", v),
            ch_code(ch), int'(VEC[v][6:1]));
      check(gpo[ch] == VEC[v][0], $sformatf("R1/R2/R8 vector %0d gpo", v),
            int'(gpo[ch]), int'(VEC[v][0]));
    end
    clear_cfg();
    esel = '0;
    epin = 1'b0;

    // R3 R4 blink windows and period
    for (int s = 0; s < 4; s++) begin
      int per, onw, n, on;
      bsel = 2'(s);
      cfg[0] = 8'h45;
      per = (s[1] ? PL : PS) * TDIV;
      onw = (s[0] ? ONS : ONL) * TDIV;
      wait_bend();
      wait_bend();
      n = 0;
      on = 0;
      for (int i = 0; i < 500; i++) begin
        @(negedge clk);
        n++;
        if (ch_code(0) != 0) on++;
        if (bend) break;
      end
      check(n == per, $sformatf("R4 period sel %0d", s), n, per);
      check(on == onw, $sformatf("R3 on-window sel %0d", s), on, onw);
    end
    clear_cfg();
    bsel = 2'b00;

    // R5 R6 ramp up at rate 01
    begin
      int gap;
      gsel = 2'b01;
      ramp_up = 1'b1;
      cfg[1] = 8'h8A;
      step_gap(1, gap);
      check(gap == 2 * TDIV / 2 * 1, "R5 step gap rate 01", gap, 2);
      cyc(40);
      check(ch_code(1) == 10, "R6 saturate at code", ch_code(1), 10);
      cfg[1] = 8'h84;
      cyc(2);
      check(ch_code(1) == 4, "R6 clamp to lowered code", ch_code(1), 4);
    end

    // R7 ramp down with one done pulse
    begin
      int pulses;
      pulses = 0;
      ramp_up = 1'b0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (rdone) pulses++;
      end
      check(ch_code(1) == 0, "R7 ramp reaches zero", ch_code(1), 0);
      check(pulses == 1, "R7 one done pulse", pulses, 1);
    end

    // R5 rate 11 and R10 tick stall
    begin
      int gap, held;
      cfg[1] = 8'h00;
      cyc(2);
      gsel = 2'b11;
      ramp_up = 1'b1;
      cfg[1] = 8'h94;
      step_gap(1, gap);
      check(gap == 4 * TDIV, "R5 step gap rate 11", gap, 4 * TDIV);
      tick = 1'b0;
      cyc(3);
      held = ch_code(1);
      cyc(50);
      check(ch_code(1) == held, "R10 stall without tick", ch_code(1), held);
      tick = 1'b1;
      cyc(20 * 4 * TDIV + 20);
      check(ch_code(1) == 20, "R10 resumes to code", ch_code(1), 20);
    end
    clear_cfg();

    // R9 pin-controlled ramp ignores direction input
    begin
      int pulses;
      gsel = 2'b01;
      ramp_up = 1'b0;
      esel = '0;
      esel[2] = 1'b1;
      cfg[2] = 8'h86;
      epin = 1'b0;
      cyc(6);
      check(ch_code(2) == 0, "R9 dark before pin", ch_code(2), 0);
      epin = 1'b1;
      cyc(6 * TDIV + 12);
      check(ch_code(2) == 6, "R9 pin high ramps up", ch_code(2), 6);
      ramp_up = 1'b1;
      epin = 1'b0;
      pulses = 0;
      for (int i = 0; i < 6 * TDIV + 20; i++) begin
        @(negedge clk);
        if (rdone) pulses++;
      end
      check(ch_code(2) == 0, "R9 pin low ramps down", ch_code(2), 0);
      check(pulses == 1, "R9 done pulse on pin ramp", pulses, 1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule